// File: doc/BRIEF.md
# Microcoded Byte ALU with Carry Policy and Parity Check

This block is the arithmetic-logic stage of a microprogrammed storage controller. It combines a byte from the input-assembly bus (operand A) with a second byte (operand B), which can be inverted by a microinstruction bit before use. A 3-bit function code selects the operation and the carry policy. The add codes choose among a carry-in of zero, a carry-in of one, or a carry-in taken from a saved carry flag. Some codes also store the carry-out into that flag. The three logic codes are AND, OR and exclusive OR.

The result bus carries two side signals: a zero indication and an odd parity bit generated from the result. The parity bit is also compared against a parity predicted from the operand parity bits, together with the internal carry or generate vectors. A disagreement is reported one cycle later as an error pulse, so a fault in the datapath or a bad operand parity shows up without a second copy of the adder. A pass-through mode puts operand A on the result bus unchanged. The carry flag and the error pulse only act on cycles that carry an execute strobe.

Top module: `uc_byte_alu`

## Requirements
- R1: Function code 000 gives y = A + B' with carry-in 0, and code 001 gives y = A + B' + 1. Here B' is B after the optional inversion. c_out is the carry out of bit 7. Neither code changes c_flag.
- R2: Code 010 gives A AND B', code 011 gives A OR B', and code 111 gives A XOR B'. c_out is 0 for all three.
- R3: Codes 100 and 101 add like 000 and 001, and they also store c_out into c_flag at the clock edge of an executed cycle. Code 110 adds with c_flag as carry-in and stores its own c_out into c_flag.
- R4: When inv_b is 1, every bit of B is inverted before it reaches the adder and the logic functions. This allows subtraction as A + ~B + 1 with code 001.
- R5: c_flag changes only at a clock edge where exec_en is 1, pass_a is 0 and the code is 100, 101 or 110. A synchronous reset (rst high) clears it to 0.
- R6: y_zero is 1 exactly when y_bus is 0x00.
- R7: y_par is odd parity over y_bus. It is 1 when y_bus holds an even number of ones.
- R8: Operand parity bits are odd parity (a_par is 1 when a_bus has an even number of ones; b_par likewise for b_bus). If the result parity disagrees with the parity predicted from a_par, b_par and the internal carries on a cycle with exec_en high, alu_err is 1 for the following cycle only. With correct operand parity, or with exec_en low, alu_err stays 0. alu_err is 0 after reset.
- R9: With pass_a at 1, y_bus equals a_bus and c_out is 0, whatever the code and B. c_flag keeps its value, and the parity prediction uses a_par alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Execute strobe for the current microinstruction |
| fn_code | input | 3 | Function and carry-policy code |
| inv_b | input | 1 | Invert operand B |
| pass_a | input | 1 | Pass operand A to the result |
| a_bus | input | 8 | Operand A |
| a_par | input | 1 | Odd parity bit of operand A |
| b_bus | input | 8 | Operand B |
| b_par | input | 1 | Odd parity bit of operand B |
| y_bus | output | 8 | Result |
| y_par | output | 1 | Odd parity bit of the result |
| y_zero | output | 1 | Result equals zero |
| c_out | output | 1 | Carry out of the current add |
| c_flag | output | 1 | Saved carry flag |
| alu_err | output | 1 | Parity-check error pulse, one cycle after the operation |

## Verification
A vector table steps through all eight function codes with operands chosen to expose different behaviour. Some sums overflow to exactly zero, which tests carry-out together with the zero flag. Some adds run with carry-in 1, or with the saved carry chained across consecutive vectors, so a wrong carry source gives a different sum. Logic operands are picked so that AND, OR and XOR each give a distinct byte, and inverted-B cases separate subtraction from addition. Directed cases then feed a deliberately wrong operand parity with and without the execute strobe, and use pass mode with a clashing code and a bad B parity. They also check that a strobe-less latching code and a reset each leave the carry flag where the requirements place it.

// File: rtl/uc_alu_pkg.sv
package uc_alu_pkg;

  // datapath operation chosen by the function code
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_AND = 2'd1,
    OP_OR  = 2'd2,
    OP_XOR = 2'd3
  } alu_op_e;

  // where the adder's carry-in comes from
  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_src_e;

  typedef struct packed {
    alu_op_e  op;
    cin_src_e cin_src;
    logic     keep_carry;
  } alu_ctrl_t;

endpackage

// File: rtl/uc_alu_decode.sv
module uc_alu_decode
  import uc_alu_pkg::*;
(
  input  logic [2:0] fn_code,
  output alu_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '{op: OP_ADD, cin_src: CIN_ZERO, keep_carry: 1'b0};
    case (fn_code)
      3'b000: ctrl = '{op: OP_ADD, cin_src: CIN_ZERO, keep_carry: 1'b0};
      3'b001: ctrl = '{op: OP_ADD, cin_src: CIN_ONE,  keep_carry: 1'b0};
      3'b010: ctrl = '{op: OP_AND, cin_src: CIN_ZERO, keep_carry: 1'b0};
      3'b011: ctrl = '{op: OP_OR,  cin_src: CIN_ZERO, keep_carry: 1'b0};
      3'b100: ctrl = '{op: OP_ADD, cin_src: CIN_ZERO, keep_carry: 1'b1};
      3'b101: ctrl = '{op: OP_ADD, cin_src: CIN_ONE,  keep_carry: 1'b1};
      3'b110: ctrl = '{op: OP_ADD, cin_src: CIN_FLAG, keep_carry: 1'b1};
      default: ctrl = '{op: OP_XOR, cin_src: CIN_ZERO, keep_carry: 1'b0};
    endcase
  end

  // R3: only add codes may ask for the carry to be kept
  always_comb begin
    keep_only_on_add_chk: assert (!(ctrl.keep_carry && ctrl.op != OP_ADD));
  end

endmodule

// File: rtl/uc_alu_core.sv
module uc_alu_core
  import uc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic           cin,
  input  logic           inv_b,
  input  logic           pass_a,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  output logic [W-1:0]   y,
  output logic           cout,
  output logic [W-1:0]   carry_vec,
  output logic [W-1:0]   gen_vec
);

  localparam int PACKW = 2 * W + 1;

  // ripple add returning {carry out, carry into each bit, sum}
  function automatic logic [PACKW-1:0] ripple_add(input logic [W-1:0] x,
                                                 input logic [W-1:0] z,
                                                 input logic ci);
    logic [W:0]   c;
    logic [W-1:0] s;
    c[0] = ci;
    for (int i = 0; i < W; i++) begin
      s[i]   = x[i] ^ z[i] ^ c[i];
      c[i+1] = (x[i] & z[i]) | (c[i] & (x[i] ^ z[i]));
    end
    return {c[W], c[W-1:0], s};
  endfunction

  logic [W-1:0]     b_eff;
  logic [PACKW-1:0] add_pk;

  always_comb begin
    b_eff     = inv_b ? ~b_in : b_in;
    add_pk    = ripple_add(a_in, b_eff, cin);
    carry_vec = add_pk[2*W-1:W];
    gen_vec   = a_in & b_eff;
    cout      = 1'b0;
    case (op)
      OP_ADD: begin
        y    = add_pk[W-1:0];
        cout = add_pk[PACKW-1];
      end
      OP_AND:  y = a_in & b_eff;
      OP_OR:   y = a_in | b_eff;
      default: y = a_in ^ b_eff;
    endcase
    if (pass_a) begin
      y    = a_in;
      cout = 1'b0;
    end
  end

endmodule

// File: rtl/uc_alu_parchk.sv
module uc_alu_parchk
  import uc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic         inv_b,
  input  logic         pass_a,
  input  logic         a_par,
  input  logic         b_par,
  input  logic [W-1:0] carry_vec,
  input  logic [W-1:0] gen_vec,
  input  logic [W-1:0] y,
  output logic         y_par,
  output logic         mismatch
);

  // inverting an odd number of bits flips the data parity
  localparam logic INV_FLIPS = ((W % 2) == 1);

  logic xa, xb, pred_x;

  always_comb begin
    xa = ~a_par;
    xb = ~b_par ^ (inv_b & INV_FLIPS);
    case (op)
      OP_ADD:  pred_x = xa ^ xb ^ (^carry_vec);
      OP_AND:  pred_x = ^gen_vec;
      OP_OR:   pred_x = xa ^ xb ^ (^gen_vec);
      default: pred_x = xa ^ xb;
    endcase
    if (pass_a) pred_x = xa;
    y_par    = ~(^y);
    mismatch = (^y) != pred_x;
  end

endmodule

// File: rtl/uc_byte_alu.sv
module uc_byte_alu
  import uc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exec_en,
  input  logic [2:0]   fn_code,
  input  logic         inv_b,
  input  logic         pass_a,
  input  logic [W-1:0] a_bus,
  input  logic         a_par,
  input  logic [W-1:0] b_bus,
  input  logic         b_par,
  output logic [W-1:0] y_bus,
  output logic         y_par,
  output logic         y_zero,
  output logic         c_out,
  output logic         c_flag,
  output logic         alu_err
);

  alu_ctrl_t    ctrl;
  logic         cin;
  logic         latch_en;
  logic         par_mismatch;
  logic [W-1:0] carry_vec;
  logic [W-1:0] gen_vec;

  uc_alu_decode u_dec (
    .fn_code (fn_code),
    .ctrl    (ctrl)
  );

  always_comb begin
    case (ctrl.cin_src)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = c_flag;
      default:  cin = 1'b0;
    endcase
  end

  uc_alu_core #(.W(W)) u_core (
    .op        (ctrl.op),
    .cin       (cin),
    .inv_b     (inv_b),
    .pass_a    (pass_a),
    .a_in      (a_bus),
    .b_in      (b_bus),
    .y         (y_bus),
    .cout      (c_out),
    .carry_vec (carry_vec),
    .gen_vec   (gen_vec)
  );

  uc_alu_parchk #(.W(W)) u_par (
    .op        (ctrl.op),
    .inv_b     (inv_b),
    .pass_a    (pass_a),
    .a_par     (a_par),
    .b_par     (b_par),
    .carry_vec (carry_vec),
    .gen_vec   (gen_vec),
    .y         (y_bus),
    .y_par     (y_par),
    .mismatch  (par_mismatch)
  );

  assign y_zero   = (y_bus == '0);
  assign latch_en = exec_en & ctrl.keep_carry & ~pass_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_flag  <= 1'b0;
      alu_err <= 1'b0;
    end else begin
      if (latch_en) c_flag <= c_out;
      alu_err <= exec_en & par_mismatch;
    end
  end

  // R5
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(exec_en && fn_code[2] && (fn_code != 3'b111) && !pass_a) |=> $stable(c_flag));

  // R3
  carry_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_en && !pass_a && (fn_code inside {3'b100, 3'b101, 3'b110}))
      |=> (c_flag == $past(c_out)));

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_en && (y_par == ~(^y_bus)) && par_mismatch) |=> alu_err);

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> !alu_err);

  // R9
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    pass_a |-> (y_bus == a_bus) && !c_out);

endmodule

// File: tb/uc_byte_alu_tb_top.sv
module uc_byte_alu_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       exec_en;
  logic [2:0] fn_code;
  logic       inv_b;
  logic       pass_a;
  logic [7:0] a_bus;
  logic       a_par;
  logic [7:0] b_bus;
  logic       b_par;
  logic [7:0] y_bus;
  logic       y_par;
  logic       y_zero;
  logic       c_out;
  logic       c_flag;
  logic       alu_err;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;

  uc_byte_alu #(.W(8)) dut_i (
    .clk(clk), .rst(rst), .exec_en(exec_en), .fn_code(fn_code), .inv_b(inv_b),
    .pass_a(pass_a), .a_bus(a_bus), .a_par(a_par), .b_bus(b_bus), .b_par(b_par),
    .y_bus(y_bus), .y_par(y_par), .y_zero(y_zero), .c_out(c_out),
    .c_flag(c_flag), .alu_err(alu_err)
  );

  typedef struct packed {
    logic [2:0] fn;
    logic       inv;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] r;
    logic       co;
    logic       cf;
  } vec_t;

  // fn, inv, A, B, expected result, carry out, carry flag afterwards
  localparam vec_t VT [13] = '{
    '{3'b000, 1'b0, 8'h12, 8'h34, 8'h46, 1'b0, 1'b0},
    '{3'b001, 1'b0, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0},
    '{3'b100, 1'b0, 8'h80, 8'h80, 8'h00, 1'b1, 1'b1},
    '{3'b110, 1'b0, 8'h01, 8'h01, 8'h03, 1'b0, 1'b0},
    '{3'b101, 1'b0, 8'hF0, 8'h0F, 8'h00, 1'b1, 1'b1},
    '{3'b110, 1'b0, 8'h10, 8'h20, 8'h31, 1'b0, 1'b0},
    '{3'b001, 1'b1, 8'h50, 8'h20, 8'h30, 1'b1, 1'b0},
    '{3'b010, 1'b0, 8'hF0, 8'h3C, 8'h30, 1'b0, 1'b0},
    '{3'b011, 1'b0, 8'hF0, 8'h0C, 8'hFC, 1'b0, 1'b0},
    '{3'b111, 1'b0, 8'hAA, 8'hFF, 8'h55, 1'b0, 1'b0},
    '{3'b010, 1'b1, 8'hF0, 8'h0F, 8'hF0, 1'b0, 1'b0},
    '{3'b000, 1'b1, 8'h05, 8'h05, 8'hFF, 1'b0, 1'b0},
    '{3'b100, 1'b1, 8'h05, 8'h05, 8'hFF, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] fn, input logic inv);
    if (inv) return "R4";
    case (fn)
      3'b000, 3'b001: return "R1";
      3'b010, 3'b011, 3'b111: return "R2";
      default: return "R3";
    endcase
  endfunction

  // drive at a falling edge, check outputs, then registered state one cycle on
  task automatic apply(input logic [2:0] fn, input logic inv, input logic pa,
                       input logic [7:0] a, input logic [7:0] b,
                       input logic bad_a, input logic ex);
    @(negedge clk);
    fn_code = fn; inv_b = inv; pass_a = pa; a_bus = a; b_bus = b;
    a_par = (~^a) ^ bad_a; b_par = ~^b; exec_en = ex;
    #2;
  endtask

  task automatic run_vec(input vec_t v);
    string rq;
    rq = req_of(v.fn, v.inv);
    apply(v.fn, v.inv, 1'b0, v.a, v.b, 1'b0, 1'b1);
    chk(y_bus == v.r, rq, "result", y_bus, v.r);
    chk(c_out == v.co, rq, "carry out", c_out, v.co);
    chk(y_zero == (v.r == 8'h00), "R6", "zero flag", y_zero, v.r == 8'h00);
    chk(y_par == ~^v.r, "R7", "result parity", y_par, ~^v.r);
    @(negedge clk);
    chk(c_flag == v.cf, "R5", "carry flag", c_flag, v.cf);
    chk(alu_err == 1'b0, "R8", "error on good parity", alu_err, 0);
  endtask

  initial begin
    rst = 1'b1; exec_en = 1'b0; fn_code = 3'b000; inv_b = 1'b0; pass_a = 1'b0;
    a_bus = 8'h00; b_bus = 8'h00; a_par = 1'b1; b_par = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    // reset state, R5 and R8
    chk(c_flag == 1'b0, "R5", "carry flag after reset", c_flag, 0);
    chk(alu_err == 1'b0, "R8", "error after reset", alu_err, 0);

    for (int i = 0; i < 13; i++) run_vec(VT[i]);

    // R5: set the flag, then a latching code without strobe leaves it
    apply(3'b100, 1'b0, 1'b0, 8'h80, 8'h80, 1'b0, 1'b1);
    @(negedge clk);
    chk(c_flag == 1'b1, "R3", "flag set by code 100", c_flag, 1);
    apply(3'b100, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    chk(c_flag == 1'b1, "R5", "flag held without strobe", c_flag, 1);
    // R5: non-latching add with carry-out 0 leaves flag at 1
    apply(3'b000, 1'b0, 1'b0, 8'h01, 8'h01, 1'b0, 1'b1);
    @(negedge clk);
    chk(c_flag == 1'b1, "R5", "flag held by code 000", c_flag, 1);

    // R9: pass mode with latching code and bad B parity
    apply(3'b110, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b1);
    b_par = ~b_par;
    #1;
    chk(y_bus == 8'h00, "R9", "pass result", y_bus, 0);
    chk(c_out == 1'b0, "R9", "pass carry out", c_out, 0);
    chk(y_zero == 1'b1, "R9", "pass zero flag", y_zero, 1);
    @(negedge clk);
    chk(c_flag == 1'b1, "R9", "pass keeps flag", c_flag, 1);
    chk(alu_err == 1'b0, "R9", "pass ignores B parity", alu_err, 0);
    apply(3'b111, 1'b0, 1'b1, 8'hA5, 8'h3C, 1'b0, 1'b1);
    chk(y_bus == 8'hA5, "R9", "pass result A5", y_bus, 8'hA5);

    // R8: bad A parity with strobe gives a one-cycle pulse
    apply(3'b000, 1'b0, 1'b0, 8'h01, 8'h02, 1'b1, 1'b1);
    apply(3'b000, 1'b0, 1'b0, 8'h01, 8'h02, 1'b0, 1'b1);
    chk(alu_err == 1'b1, "R8", "error after bad parity", alu_err, 1);
    @(negedge clk);
    chk(alu_err == 1'b0, "R8", "error pulse ends", alu_err, 0);
    // R8: bad parity without strobe
    apply(3'b001, 1'b0, 1'b0, 8'h33, 8'h44, 1'b1, 1'b0);
    @(negedge clk);
    chk(alu_err == 1'b0, "R8", "no error without strobe", alu_err, 0);

    // R5: synchronous reset clears the flag
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #2;
    chk(c_flag == 1'b0, "R5", "flag cleared by reset", c_flag, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule